// File: doc/BRIEF.md
# Floating-Point Status Word Unit

This block holds the 32-bit status word that sits beside a single-precision arithmetic unit. The datapath computes its result in the usual way. In the same cycle it strobes this unit with the raw exception indications it saw: invalid, divide-by-zero, overflow, underflow and inexact, plus one bit for an input or output denormal. The unit then does three things. It replaces the per-operation cause bits. It accumulates sticky flags for the exceptions that are not trapped. It keeps a summary bit set while any sticky flag is set.

When a recorded cause meets its enable bit, the unit raises a trap request that carries a fixed exception number. The unimplemented-processing cause always counts as enabled. Software writes to the word pass through a merge rule. Under that rule the cause bits can only be cleared, and the summary bit is always recomputed. The two low bits of the word drive the rounding mode used by the datapath. The unit also registers the zero and sign condition flags of the last arithmetic result.

Top module: `fpsw_unit`

## Requirements
- R1: After reset, `fpsw_o` is 0, and `trap_o`, `trap_code_o`, `zero_o` and `sign_o` are 0.
- R2: An update (`upd_i` high, `wr_i` low) first clears cause bits [7:2] of the word and then records the new causes. Bit 2 holds invalid, bit 3 overflow, bit 4 divide-by-zero, bit 5 underflow and bit 6 inexact, taken from `exc_i[0]` through `exc_i[4]` in that order. The new word is visible one cycle after the strobe.
- R3: On an update, sticky flag bit 26+i (i = 0..4, same exception order as R2) is set when `exc_i[i]` is 1 and enable bit 10+i is 0. An update never clears a sticky flag.
- R4: On an update with `dnrm_i` high, cause bit 7 (unimplemented processing) is set only when the flush bit 8 is 0.
- R5: Bit 31 (summary) is 1 whenever any of bits [30:26] is 1. An update sets bit 31 when its resulting sticky flags are nonzero. An update leaves bit 31 unchanged otherwise.
- R6: `trap_o` is high in the cycle after an update whose new cause bits [7:2], ANDed with the enables {1, bits[14:10]}, are nonzero. Bit 7 is always enabled. While `trap_o` is high, `trap_code_o` equals 21. Otherwise it is 0.
- R7: A write (`wr_i` high) sets the word to (old OR 0x7fffff03) AND the written value. Bit 31 of the written value is ignored, and bit 31 of the result is set to the OR of result bits [30:26]. A write in the same cycle as `upd_i` wins, and that update is discarded along with its trap and condition flags.
- R8: `rmode_o` equals bits [1:0] of the word. The codes are 0 round-to-nearest-even, 1 toward zero, 2 toward +infinity and 3 toward -infinity.
- R9: On an update, `zero_o` becomes 1 exactly when `res_i[30:0]` is 0, and `sign_o` becomes `res_i[31]`. Both hold their values otherwise.
- R10: An update with no exception and no denormal indication clears the causes only. It leaves the other bits of the word unchanged and raises no trap. Cycles without an update or a write change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| upd_i | input | 1 | Flag update strobe from the datapath |
| exc_i | input | 5 | Exception indications: invalid, overflow, div-by-zero, underflow, inexact (bit 0 to 4) |
| dnrm_i | input | 1 | Input or output denormal seen |
| res_i | input | 32 | Operation result for the zero and sign flags |
| wr_i | input | 1 | Software write strobe |
| wr_data_i | input | 32 | Software write value |
| fpsw_o | output | 32 | Status word |
| rmode_o | output | 2 | Rounding mode to the datapath |
| zero_o | output | 1 | Result zero flag |
| sign_o | output | 1 | Result sign flag |
| trap_o | output | 1 | Trap request |
| trap_code_o | output | 8 | Exception number while trap_o is high |

## Verification
The bench builds the unit with its default parameters: an 8-bit trap code of 21 and an all-zero reset word. With those defaults the summary and sticky invariants hold from reset. Random software writes reach every mix of enable bits, flush bit and rounding mode. Random updates with sparse exception vectors then land on each mix. This covers trapped and untrapped exceptions side by side, and denormals both with and without flush. Directed steps add write-update collisions and attempts to set cause bits by writing.

// File: rtl/fpsw_pkg.sv
package fpsw_pkg;
  localparam int SW_W      = 32;
  localparam int NEXC      = 5;
  localparam int RM_W      = 2;
  localparam int CAUSE_LSB = 2;
  localparam int DN_BIT    = CAUSE_LSB + NEXC + 1;
  localparam int EN_LSB    = 10;
  localparam int FLAG_LSB  = 26;
  localparam int FS_BIT    = SW_W - 1;
  localparam logic [SW_W-1:0] WR_KEEP = 32'h7fff_ff03;
  localparam logic [SW_W-1:0] FS_MASK = 32'h8000_0000;
endpackage

// File: rtl/fpsw_upd.sv
module fpsw_upd
  import fpsw_pkg::*;
(
  input  logic [SW_W-1:0] cur_i,
  input  logic [NEXC-1:0] exc_i,
  input  logic            dnrm_i,
  output logic [SW_W-1:0] nxt_o,
  output logic            trap_o
);
  logic [NEXC-1:0] flg;
  logic [NEXC:0]   cause;
  logic [NEXC:0]   enab;

  // sticky only when the exception is not trapped
  for (genvar i = 0; i < NEXC; i++) begin : g_flag
    assign flg[i] = cur_i[FLAG_LSB+i] | (exc_i[i] & ~cur_i[EN_LSB+i]);
  end

  assign cause = {dnrm_i & ~cur_i[DN_BIT], exc_i};
  assign enab  = {1'b1, cur_i[EN_LSB +: NEXC]};

  always_comb begin
    nxt_o = cur_i;
    nxt_o[CAUSE_LSB +: NEXC+1] = cause;
    nxt_o[FLAG_LSB +: NEXC]    = flg;
    nxt_o[FS_BIT]              = cur_i[FS_BIT] | (|flg);
  end

  assign trap_o = |(cause & enab);
endmodule

// File: rtl/fpsw_wmerge.sv
module fpsw_wmerge
  import fpsw_pkg::*;
(
  input  logic [SW_W-1:0] cur_i,
  input  logic [SW_W-1:0] data_i,
  output logic [SW_W-1:0] nxt_o
);
  logic [SW_W-1:0] t;

  // masked-out bits can only be cleared; summary is rebuilt
  assign t     = (cur_i | WR_KEEP) & data_i & ~FS_MASK;
  assign nxt_o = t | (FS_MASK & {SW_W{|t[FLAG_LSB +: NEXC]}});
endmodule

// File: rtl/fpsw_unit.sv
module fpsw_unit
  import fpsw_pkg::*;
#(
  parameter int                TRAP_W   = 8,
  parameter logic [TRAP_W-1:0] TRAP_NUM = 21,
  parameter logic [SW_W-1:0]   RST_VAL  = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic [NEXC-1:0]   exc_i,
  input  logic              dnrm_i,
  input  logic [SW_W-1:0]   res_i,
  input  logic              wr_i,
  input  logic [SW_W-1:0]   wr_data_i,
  output logic [SW_W-1:0]   fpsw_o,
  output logic [RM_W-1:0]   rmode_o,
  output logic              zero_o,
  output logic              sign_o,
  output logic              trap_o,
  output logic [TRAP_W-1:0] trap_code_o
);
  logic [SW_W-1:0] sw_q, upd_nxt, wr_nxt;
  logic            upd_trap, trap_q, zero_q, sign_q, upd_go;

  assign upd_go = upd_i & ~wr_i;

  fpsw_upd u_upd (
    .cur_i  (sw_q),
    .exc_i  (exc_i),
    .dnrm_i (dnrm_i),
    .nxt_o  (upd_nxt),
    .trap_o (upd_trap)
  );

  fpsw_wmerge u_wr (
    .cur_i  (sw_q),
    .data_i (wr_data_i),
    .nxt_o  (wr_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_q   <= RST_VAL;
      trap_q <= 1'b0;
      zero_q <= 1'b0;
      sign_q <= 1'b0;
    end else begin
      trap_q <= upd_go & upd_trap;
      if (wr_i)        sw_q <= wr_nxt;
      else if (upd_i)  sw_q <= upd_nxt;
      if (upd_go) begin
        zero_q <= ~|res_i[SW_W-2:0];
        sign_q <= res_i[SW_W-1];
      end
    end
  end

  assign fpsw_o      = sw_q;
  assign rmode_o     = sw_q[RM_W-1:0];
  assign zero_o      = zero_q;
  assign sign_o      = sign_q;
  assign trap_o      = trap_q;
  assign trap_code_o = trap_q ? TRAP_NUM : '0;

  p_cause_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_go && exc_i == '0 && !dnrm_i) |=> fpsw_o[CAUSE_LSB +: NEXC+1] == '0);

  p_sticky_keep_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> (fpsw_o[FLAG_LSB +: NEXC] & $past(fpsw_o[FLAG_LSB +: NEXC]))
              == $past(fpsw_o[FLAG_LSB +: NEXC]));

  p_flush_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_go && dnrm_i && !fpsw_o[DN_BIT]) |=> trap_o);

  p_summary_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|fpsw_o[FLAG_LSB +: NEXC]) |-> fpsw_o[FS_BIT]);

  p_trap_only_upd_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_go |=> !trap_o);

  p_wr_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> $stable(zero_o) && $stable(sign_o));
endmodule

// File: tb/sim_fpsw_unit.sv
module sim_fpsw_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd = 1'b0, dnrm = 1'b0, wr = 1'b0;
  logic [4:0]  exc = '0;
  logic [31:0] res = '0, wdata = '0;
  logic [31:0] fpsw;
  logic [1:0]  rmode;
  logic        zero, sign, trap;
  logic [7:0]  code;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] m_sw = '0;
  logic        m_trap = 0, m_zero = 0, m_sign = 0;

  always #4 clk = ~clk;

  fpsw_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .upd_i(upd), .exc_i(exc), .dnrm_i(dnrm),
    .res_i(res), .wr_i(wr), .wr_data_i(wdata), .fpsw_o(fpsw), .rmode_o(rmode),
    .zero_o(zero), .sign_o(sign), .trap_o(trap), .trap_code_o(code)
  );

  function automatic logic [31:0] f_wr(logic [31:0] old, logic [31:0] d);
    logic [31:0] t;
    t = (old | 32'h7fffff03) & {1'b0, d[30:0]};
    t[31] = |t[30:26];
    return t;
  endfunction

  function automatic logic [32:0] f_upd(logic [31:0] old, logic [4:0] e, logic dn);
    logic [31:0] n;
    logic [5:0]  c;
    n = old;
    c = {dn & ~old[8], e};
    n[7:2] = c;
    n[30:26] = old[30:26] | (e & ~old[14:10]);
    n[31] = old[31] | (|n[30:26]);
    return {|(c & {1'b1, old[14:10]}), n};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(bit w, logic [31:0] d, bit u, logic [4:0] e, bit dn,
                      logic [31:0] r, string tag);
    logic [32:0] x;
    @(negedge clk);
    wr = w; wdata = d; upd = u; exc = e; dnrm = dn; res = r;
    m_trap = 0;
    if (w) m_sw = f_wr(m_sw, d);
    else if (u) begin
      x = f_upd(m_sw, e, dn);
      m_sw = x[31:0]; m_trap = x[32];
      m_zero = (r[30:0] == 0); m_sign = r[31];
    end
    @(posedge clk);
    @(negedge clk);
    wr = 0; upd = 0;
    chk(tag, fpsw, m_sw);
    chk("R6 trap", {31'b0, trap}, {31'b0, m_trap});
    chk("R6 code", {24'b0, code}, m_trap ? 32'd21 : 32'd0);
    chk("R8 rmode", {30'b0, rmode}, {30'b0, m_sw[1:0]});
    chk("R9 zero/sign", {30'b0, zero, sign}, {30'b0, m_zero, m_sign});
    chk("R5 summary", {31'b0, fpsw[31]}, {31'b0, fpsw[31] | (|fpsw[30:26])});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #1;
    chk("R1 fpsw", fpsw, 32'h0);
    chk("R1 trap", {23'b0, trap, code}, 32'h0);
    chk("R1 zero/sign", {30'b0, zero, sign}, 32'h0);
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    step(0, 0, 1, 5'h1f, 0, 32'h3f80_0000, "R3 untrapped sticky");
    chk("R3 flags", {27'b0, fpsw[30:26]}, 32'h1f);
    step(0, 0, 1, 5'h00, 0, 32'h0, "R10 quiet update");
    chk("R10 causes", {26'b0, fpsw[7:2]}, 32'h0);
    step(1, 32'hffff_ffff, 0, 0, 0, 0, "R7 bit31 ignored");
    step(0, 0, 1, 5'h1f, 0, 32'h1, "R2 causes");
    step(1, 32'hffff_ffff, 0, 0, 0, 0, "R7 causes kept by ones");
    chk("R2 causes", {26'b0, fpsw[7:2]}, 32'h1f);
    step(1, 32'h0, 0, 0, 0, 0, "R7 clear all");
    chk("R5 cleared", {31'b0, fpsw[31]}, 32'h0);
    step(1, 32'h0000_0400, 0, 0, 0, 0, "R7 enable invalid");
    step(0, 0, 1, 5'h01, 0, 32'h8000_0000, "R6 trapped invalid");
    chk("R6 trap fires", {31'b0, trap}, 32'h1);
    chk("R3 no sticky when enabled", {27'b0, fpsw[30:26]}, 32'h0);
    step(0, 0, 1, 5'h00, 1, 32'h0, "R4 denormal no flush");
    chk("R4 cause", {31'b0, fpsw[7]}, 32'h1);
    step(1, 32'h0000_0100, 0, 0, 0, 0, "R7 flush on");
    step(0, 0, 1, 5'h00, 1, 32'h5, "R4 denormal flushed");
    chk("R4 no cause", {30'b0, fpsw[7], trap}, 32'h0);
    step(1, 32'h0000_0003, 1, 5'h1f, 1, 32'h0, "R7 write wins");
    for (int m = 0; m < 4; m++) step(1, m, 0, 0, 0, 0, "R8 mode write");
    step(0, 0, 0, 5'h1f, 1, 32'h0, "R10 idle");

    for (int i = 0; i < 3000; i++) begin
      int r;
      logic [31:0] d;
      r = $urandom % 8;
      d = $urandom;
      step(r == 0, d, r >= 3 || (r == 0 && d[5]), 5'($urandom & $urandom),
           ($urandom % 4) == 0, ($urandom % 5 == 0) ? {d[31], 31'b0} : $urandom,
           r == 0 ? "R7 random" : (r >= 3 ? "R2 random" : "R10 random"));
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule